// File: doc/BRIEF.md
# Configurable UART Transmit Channel

This block is the sending side of a serial port. Characters are written into a 16-deep queue and leave on a single serial line. Each character goes out as a frame: a low start bit, the data bits least significant first, an optional parity bit, then one or two high stop bits. Each bit lasts from one bit-rate tick to the next. The bit-rate tick comes from outside the block. Frame shape is chosen by an encoded mode word. A command word, written with a strobe, does four things: it enables or disables sending, resets the send logic, and starts or stops a break.

A local loopback mode routes the internal serial line to the receive-side output and holds the external pin at idle. The mode word is captured when a frame starts, so changing it during a frame only affects later frames. The block reports when its queue is empty and when it is full.

Top module: `uart_tx_channel`

## Requirements
- R1: After reset, `txd` is high, `fifo_empty` is 1 and `fifo_full` is 0. The transmitter starts out not enabled.
- R2: A frame is one low start bit, then the data bits LSB first, then the parity bit if one is selected, then high stop bits. Each bit is held for one `bit_tick` period. The line idles high. Frames may follow each other with no gap.
- R3: `mode_word[2:1]` selects the character length: 00 gives 8 data bits, 10 gives 7 and 11 gives 6. Data bits above the selected length are not sent.
- R4: `mode_word[5:3]` selects parity. 000 is even, 001 is odd, 010 is a constant 0 parity bit, 011 is a constant 1 parity bit, and 1xx sends no parity bit. Even and odd parity are computed over the sent data bits only.
- R5: `mode_word[7:6]` = 00 gives one stop bit and 10 gives two.
- R6: The queue holds 16 characters. `fifo_full` is 1 when it holds 16. A write while full is dropped and is never sent.
- R7: A command write loads `ctrl_data[4]` as the enable and `ctrl_data[5]` as the disable. A new frame starts only while enable is 1 and disable is 0. A frame already on the line is finished even if sending is disabled.
- R8: A command write with `ctrl_data[1]` = 1 is a one-shot send reset. It empties the queue and returns the line to idle high on the next cycle.
- R9: A command write with `ctrl_data[7]` = 1 starts a break, which holds the line low. `ctrl_data[8]` = 1 ends it. When both bits are set in one write, ending wins.
- R10: When `mode_word[9:8]` = 10, the internal line drives `rx_line` and `txd` stays high. When it is 00, `rx_line` follows `rxd_pin`.
- R11: The mode is captured when a frame starts. A mode change during a frame leaves that frame unchanged and applies to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Command word write strobe |
| ctrl_data | input | 9 | Command word: reset, enable, disable, break start and break stop bits |
| mode_word | input | 10 | Encoded frame shape and channel mode |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_valid | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to queue |
| rxd_pin | input | 1 | External receive pin, passed through in normal mode |
| fifo_empty | output | 1 | Queue holds no characters |
| fifo_full | output | 1 | Queue holds 16 characters |
| txd | output | 1 | Serial output line |
| rx_line | output | 1 | Line offered to the receive side (looped back or from the pin) |

## Verification
The hardest case to reach is a mode change while a frame is still on the line. The stimulus sends one character. It waits until the queue reads empty, which means the shifter has taken the character. It then switches to a shorter character length and queues a second character. Each expected frame is tagged with the mode it should use, so a frame built with the wrong mode shows up as a bit mismatch.

The overflow case is reached by disabling the channel and filling the queue past 16. On re-enable, exactly 16 frames must appear. The reset-during-frame case waits for the start bit, then issues the send reset.

// File: rtl/uart_tx_pkg.sv
// Shared types and mode-word decoding for the UART transmit channel.
// Assumes the mode word layout given in the brief (R3, R4, R5, R10).
package uart_tx_pkg;

    localparam int CHAR_MAX  = 8;
    localparam int FRAME_MAX = 1 + CHAR_MAX + 1 + 2;

    // Command word bit positions.
    localparam int CMD_RESET    = 1;
    localparam int CMD_ENABLE   = 4;
    localparam int CMD_DISABLE  = 5;
    localparam int CMD_BRK_ON   = 7;
    localparam int CMD_BRK_OFF  = 8;

    typedef enum logic [1:0] {
        PAR_EVEN  = 2'b00,
        PAR_ODD   = 2'b01,
        PAR_SPACE = 2'b10,
        PAR_MARK  = 2'b11
    } par_kind_e;

    typedef struct packed {
        logic [3:0] char_len;
        logic       par_on;
        par_kind_e  par;
        logic       two_stop;
    } frame_cfg_t;

    // Turn the encoded mode word into frame shape fields.
    function automatic frame_cfg_t decode_mode(input logic [9:0] m);
        frame_cfg_t c;
        case (m[2:1])
            2'b10:   c.char_len = 4'd7;
            2'b11:   c.char_len = 4'd6;
            default: c.char_len = 4'd8;
        endcase
        c.par_on   = ~m[5];
        c.par      = par_kind_e'(m[4:3]);
        c.two_stop = m[7];
        return c;
    endfunction

endpackage

// File: rtl/utx_fifo.sv
// Character queue for the transmit channel.
// Assumes: writes while full are dropped, clear has priority over all traffic.
module utx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;
    logic             do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == DEPTH_C);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    // Storage write: only accepted characters land in the array.
    always_ff @(posedge clk) begin
        if (do_wr && !clear) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end

    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !clear) |=> full);
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

endmodule

// File: rtl/utx_framer.sv
// Frame shifter: on a bit tick with a character waiting and sending allowed,
// builds the whole frame from the current mode and shifts it out one bit per tick.
// Assumes: the mode is sampled only at load, so mid-frame changes are ignored.
module utx_framer
    import uart_tx_pkg::*;
#(
    parameter int FRAME_W = FRAME_MAX,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic          run,
    input  frame_cfg_t    cfg,
    input  logic          have_data,
    input  logic [7:0]    data,
    output logic          pop,
    output logic          line,
    output logic          busy
);
    logic [FRAME_W-1:0] frame_q, frame_n;
    logic [CNT_W-1:0]   cnt_q, len_n;
    logic [CHAR_MAX-1:0] masked;
    logic               pbit, last;

    // Assemble the frame vector (LSB goes out first) and its length.
    always_comb begin
        frame_n    = '1;
        frame_n[0] = 1'b0;
        masked     = '0;
        for (int i = 0; i < CHAR_MAX; i++) begin
            if (i < int'(cfg.char_len)) begin
                frame_n[i+1] = data[i];
                masked[i]    = data[i];
            end
        end
        case (cfg.par)
            PAR_EVEN:  pbit = ^masked;
            PAR_ODD:   pbit = ~^masked;
            PAR_SPACE: pbit = 1'b0;
            default:   pbit = 1'b1;
        endcase
        if (cfg.par_on) frame_n[int'(cfg.char_len) + 1] = pbit;
        len_n = CNT_W'(1) + CNT_W'(cfg.char_len) + CNT_W'(cfg.par_on)
              + (cfg.two_stop ? CNT_W'(2) : CNT_W'(1));
    end

    assign last = busy && (cnt_q == CNT_W'(1));
    assign pop  = tick && run && have_data && (!busy || last);
    assign line = busy ? frame_q[0] : 1'b1;

    // Load, shift and finish frames on bit ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            busy    <= 1'b0;
            frame_q <= '1;
            cnt_q   <= '0;
        end else if (tick) begin
            if (pop) begin
                busy    <= 1'b1;
                frame_q <= frame_n;
                cnt_q   <= len_n;
            end else if (last) begin
                busy    <= 1'b0;
                frame_q <= '1;
                cnt_q   <= '0;
            end else if (busy) begin
                frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                cnt_q   <= cnt_q - 1'b1;
            end
        end
    end

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |=> (busy && !line));
    a_r11_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !clear) |=> $stable(frame_q));

endmodule

// File: rtl/utx_ctrl.sv
// Command decoder: holds enable, disable and break state from command writes
// and produces the one-shot send reset. Assumes every write carries a full word.
module utx_ctrl
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [8:0] ctrl_data,
    output logic       run,
    output logic       brk,
    output logic       soft_rst
);
    logic en_q, dis_q, brk_q;

    assign run      = en_q && !dis_q;
    assign brk      = brk_q;
    assign soft_rst = ctrl_wr && ctrl_data[CMD_RESET];

    // Capture enable/disable on every command write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            dis_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q  <= ctrl_data[CMD_ENABLE];
            dis_q <= ctrl_data[CMD_DISABLE];
        end
    end

    // Break start/stop, with stop taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 brk_q <= 1'b0;
        else if (ctrl_wr && ctrl_data[CMD_BRK_OFF]) brk_q <= 1'b0;
        else if (ctrl_wr && ctrl_data[CMD_BRK_ON])  brk_q <= 1'b1;
    end

    a_r9_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_data[CMD_BRK_OFF]) |=> !brk);

endmodule

// File: rtl/uart_tx_channel.sv
// Top of the transmit channel: queue, frame shifter, command decoder, and the
// break/loopback line steering. Assumes bit_tick is a one-cycle pulse.
module uart_tx_channel
    import uart_tx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [8:0]        ctrl_data,
    input  logic [9:0]        mode_word,
    input  logic              bit_tick,
    input  logic              wr_valid,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              rxd_pin,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              txd,
    output logic              rx_line
);
    logic              run, brk, soft_rst, pop, fr_line, fr_busy, loopback, int_line;
    logic [CHAR_W-1:0] head;
    frame_cfg_t        cfg;

    assign cfg      = decode_mode(mode_word);
    assign loopback = (mode_word[9:8] == 2'b10);
    assign int_line = brk ? 1'b0 : fr_line;
    assign txd      = loopback ? 1'b1 : int_line;
    assign rx_line  = loopback ? int_line : rxd_pin;

    utx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .run(run), .brk(brk), .soft_rst(soft_rst)
    );

    utx_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(soft_rst), .wr_en(wr_valid),
        .wr_data(wr_data), .rd_en(pop), .rd_data(head),
        .empty(fifo_empty), .full(fifo_full)
    );

    utx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .clear(soft_rst), .tick(bit_tick), .run(run),
        .cfg(cfg), .have_data(!fifo_empty), .data(head[7:0]),
        .pop(pop), .line(fr_line), .busy(fr_busy)
    );

    a_r8_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (fifo_empty && !fr_busy));
    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !loopback) |-> !txd);
    a_r10_loop_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |-> txd);

endmodule

// File: tb/uart_tx_channel_tb.sv
`timescale 1ns/1ps
module uart_tx_channel_tb_top;

    typedef struct { logic [7:0] data; logic [9:0] mode; } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [8:0] ctrl_data = '0;
    logic [9:0] mode_word = 10'h020;
    logic       bit_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rxd_pin = 1'b1;
    logic       fifo_empty, fifo_full, txd, rx_line;

    uart_tx_channel dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .mode_word(mode_word), .bit_tick(bit_tick), .wr_valid(wr_valid),
        .wr_data(wr_data), .rxd_pin(rxd_pin), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .txd(txd), .rx_line(rx_line)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0, n_fail = 0, cyc = 0, tick_div = 0;
    int    frames_seen = 0, loop_txd_low = 0;
    bit    mon_en = 1'b1, loop_sel = 1'b0, in_frame = 1'b0, frame_bad = 1'b0, done = 1'b0;
    item_t exp_q[$];
    logic [11:0] exp_bits;
    int    exp_len = 0, bit_idx = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Expected frame built from R2..R5: start 0, data LSB first, parity, stop 1s.
    function automatic void build_frame(input logic [7:0] d, input logic [9:0] m,
                                        output logic [11:0] bits, output int len);
        int  w;
        bit  p;
        logic [7:0] md;
        w = (m[2:1] == 2'b10) ? 7 : (m[2:1] == 2'b11) ? 6 : 8;
        md = d & 8'((1 << w) - 1);
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < w; i++) bits[i+1] = md[i];
        len = 1 + w;
        if (!m[5]) begin
            case (m[4:3])
                2'b00: p = ^md;
                2'b01: p = ~^md;
                2'b10: p = 1'b0;
                default: p = 1'b1;
            endcase
            bits[len] = p;
            len++;
        end
        len += m[7] ? 2 : 1;
    endfunction

    // Tick generator, scoreboard monitor and watchdog, all at the falling edge.
    always @(negedge clk) begin
        logic ln;
        cyc++;
        if (rst_n && bit_tick && mon_en) begin
            ln = loop_sel ? rx_line : txd;
            if (loop_sel && !txd) loop_txd_low++;
            if (!in_frame) begin
                if (ln == 1'b0) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2/R6 unexpected start bit", 0, 1);
                    end else begin
                        item_t it;
                        it = exp_q.pop_front();
                        build_frame(it.data, it.mode, exp_bits, exp_len);
                        bit_idx = 1; in_frame = 1'b1; frame_bad = 1'b0;
                    end
                end
            end else begin
                if (ln !== exp_bits[bit_idx]) frame_bad = 1'b1;
                bit_idx++;
                if (bit_idx == exp_len) begin
                    in_frame = 1'b0;
                    frames_seen++;
                    check(!frame_bad, "R2-frame (R3 R4 R5 R11 shape)", 0, 0);
                end
            end
        end
        tick_div = (tick_div + 1) % 4;
        bit_tick = (tick_div == 0);
        if (cyc == 150000) begin
            check(1'b0, "watchdog", cyc, 0);
            finish_test();
        end
    end

    task automatic push(input logic [7:0] d, input bit expect_sent);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        if (expect_sent) exp_q.push_back('{d, mode_word});
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic ctrl(input logic [8:0] w);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_data = w;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !in_frame && fifo_empty) break;
        end
        repeat (60) @(negedge clk);
        check(exp_q.size() == 0 && !in_frame, "R2 all frames delivered", exp_q.size(), 0);
    endtask

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd idle", txd, 1);
        check(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
        check(fifo_full == 1'b0, "R1 not full", fifo_full, 0);
        rst_n = 1'b1;
        // R1: not enabled, a queued char stays queued
        push(8'h42, 1'b0);
        repeat (40) @(negedge clk);
        check(fifo_empty == 1'b0 && txd, "R1 not enabled after reset", fifo_empty, 0);
        ctrl(9'h002);
        check(fifo_empty == 1'b1, "R8 reset empties queue", fifo_empty, 1);

        // R2 basic 8N1, back to back
        ctrl(9'h010);
        mode_word = 10'h020;
        push(8'hA5, 1); push(8'h3C, 1); push(8'hFF, 1); push(8'h00, 1);
        drain();

        // R3 character lengths
        mode_word = 10'h024; push(8'h81, 1); drain();
        mode_word = 10'h026; push(8'hC7, 1); drain();

        // R4 parity kinds
        mode_word = 10'h000; push(8'h37, 1); drain();
        mode_word = 10'h008; push(8'h37, 1); drain();
        mode_word = 10'h010; push(8'h36, 1); drain();
        mode_word = 10'h018; push(8'h36, 1); drain();
        mode_word = 10'h00C; push(8'hD5, 1); drain();

        // R5 two stop bits, back to back
        mode_word = 10'h0A0; push(8'h5A, 1); push(8'h01, 1); drain();
        mode_word = 10'h080; push(8'hE3, 1); push(8'h80, 1); drain();

        // R11 mode change while a frame is on the line
        mode_word = 10'h020; push(8'h55, 1);
        for (int i = 0; i < 100 && !fifo_empty; i++) @(negedge clk);
        mode_word = 10'h026; push(8'h2A, 1);
        drain();
        mode_word = 10'h020;

        // R6 fill while disabled, overflow dropped
        ctrl(9'h000);
        for (int i = 0; i < 16; i++) push(8'(8'h10 + i), 1);
        check(fifo_full == 1'b1, "R6 full at 16", fifo_full, 1);
        push(8'hEE, 0);
        check(fifo_full == 1'b1, "R6 still full after drop", fifo_full, 1);
        f0 = frames_seen;
        ctrl(9'h010);
        repeat (8) @(negedge clk);
        check(fifo_full == 1'b0, "R6 full clears on send", fifo_full, 0);
        drain();
        check(frames_seen - f0 == 16, "R6 exactly 16 sent", frames_seen - f0, 16);

        // R7 enable and disable both set: nothing starts
        ctrl(9'h030);
        push(8'h11, 0);
        repeat (60) @(negedge clk);
        check(fifo_empty == 1'b0 && txd == 1'b1, "R7 disable overrides enable", fifo_empty, 0);
        ctrl(9'h032);
        check(fifo_empty == 1'b1, "R8 reset clears pending char", fifo_empty, 1);
        // R7 frame in flight completes after disable
        ctrl(9'h010);
        push(8'h99, 1);
        for (int i = 0; i < 100 && !fifo_empty; i++) @(negedge clk);
        ctrl(9'h020);
        push(8'h77, 0);
        repeat (80) @(negedge clk);
        check(exp_q.size() == 0 && !in_frame, "R7 in-flight frame finished", exp_q.size(), 0);
        check(fifo_empty == 1'b0, "R7 next char held while disabled", fifo_empty, 0);

        // R8 reset during a frame
        mon_en = 1'b0;
        ctrl(9'h012);
        push(8'h0F, 0);
        for (int i = 0; i < 100 && txd; i++) @(negedge clk);
        check(txd == 1'b0, "R8 frame started", txd, 0);
        ctrl(9'h012);
        check(txd == 1'b1 && fifo_empty, "R8 line idle after reset", txd, 1);
        repeat (60) @(negedge clk);
        check(txd == 1'b1, "R8 stays idle", txd, 1);

        // R9 break
        ctrl(9'h090);
        check(txd == 1'b0, "R9 break low", txd, 0);
        repeat (30) @(negedge clk);
        check(txd == 1'b0, "R9 break held", txd, 0);
        ctrl(9'h110);
        check(txd == 1'b1, "R9 break released", txd, 1);
        ctrl(9'h190);
        check(txd == 1'b1, "R9 stop wins over start", txd, 1);
        mon_en = 1'b1;

        // R10 loopback
        mode_word = 10'h220; loop_sel = 1'b1; rxd_pin = 1'b0;
        repeat (8) @(negedge clk);
        push(8'h6B, 1);
        drain();
        check(loop_txd_low == 0, "R10 txd idle in loopback", loop_txd_low, 0);
        loop_sel = 1'b0;
        mode_word = 10'h020;
        @(negedge clk);
        check(rx_line == 1'b0, "R10 normal passes pin low", rx_line, 0);
        rxd_pin = 1'b1;
        @(negedge clk);
        check(rx_line == 1'b1, "R10 normal passes pin high", rx_line, 1);

        finish_test();
    end

endmodule